// File: doc/BRIEF.md
# Sparse-Code Control Integrity Guard

This block watches the control signals of a small datapath controller. Those signals use multi-bit codes with wide spacing between the legal values. Each two-valued enable is a 3-bit code, and each mux selector is a 5-bit code. The enables are gathered into one flat vector and checked there. Their count is set by the number of key shares, key words and counter slices, plus two. The selectors arrive on a second flat vector.

Every field is compared against its legal codewords. Any mismatch counts as a fault. The result of the enable checks is registered before it reaches the controller, which keeps the controller free of combinational feedback. Selector faults go to the controller directly.

The controller is a small state machine with three states: idle, running and a terminal fault state. A fault drives it into the terminal state, where it stays until reset. The output-data write enable is gated in the same cycle that any illegal code appears. A fatal alert flop is set and holds until reset. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `spctl_guard`

## Requirements
- R1: While reset is held, and once it has been released, `err_o`, `alert_fatal_o` and `data_we_o` are all 0 and the controller is idle.
- R2: Each 3-bit enable field `en_vec_i[3*i +: 3]` is legal only as 3'b011 (on) or 3'b100 (off). Every other value of any field is a fault, including every single-bit and double-bit flip of a legal code. Inverting all three bits of a legal code gives the other legal code, so it is not a fault.
- R3: The legal set of each 5-bit selector field `sel_vec_i[5*j +: 5]` depends on bit j of `SEL_FULL_MASK`. When that bit is set, the field accepts 5'b00111, 5'b11001, 5'b01010 and 5'b10100. When it is clear, the field accepts only 5'b00111 and 5'b11001. Any value outside the set is a fault.
- R4: The terminal state is reported on `err_o` at two different times. A selector fault present before a clock edge shows on `err_o` after that edge. An enable fault is registered first, so it shows on `err_o` one edge later.
- R5: Once `err_o` is 1, it stays 1 until reset. This holds even if every code returns to a legal value and `start_i`/`done_i` keep toggling.
- R6: `alert_fatal_o` rises at the clock edge after the registered enable fault or the terminal state first appears. It then stays 1 until reset.
- R7: `data_we_o` is 1 only when all of the following hold: `out_req_i` is 1, the controller is running, no enable or selector code is illegal in the current cycle, and the block is not in the terminal state. An illegal code forces `data_we_o` low in the same cycle it appears.
- R8: When no fault is present, `start_i` moves the controller from idle to running at the next edge. `done_i` moves it from running back to idle.
- R9: Asserting `rst_ni` clears the terminal state and the alert. Reset release takes effect two clock edges after `rst_ni` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_vec_i | input | 3*NUM_EN (78) | Flat vector of 3-bit enable codes |
| sel_vec_i | input | 5*NUM_SEL (20) | Flat vector of 5-bit selector codes |
| start_i | input | 1 | Request to begin an operation |
| done_i | input | 1 | Operation finished |
| out_req_i | input | 1 | Datapath requests an output-data write |
| data_we_o | output | 1 | Gated output-data write enable |
| err_o | output | 1 | Terminal fault state flag |
| alert_fatal_o | output | 1 | Sticky fatal alert |

## Verification
The hardest situation to reach from the ports is an illegal code on one particular field while the controller is running and writing. From that point the same-cycle gating and the two different entry latencies must both be observed. Each injection therefore starts with a reset, then a start pulse and a held output request, so that `data_we_o` is high beforehand. One field is then corrupted by an XOR mask and restored after one cycle. This is repeated over every enable field with all six single-bit and double-bit masks, and over every selector field with single-bit and double-bit masks. The all-ones enable mask, and the wide codes placed on narrow-set selectors, show which corruptions are legal and which are faults.

// File: rtl/spg_pkg.sv
package spg_pkg;

  localparam int unsigned EN_W  = 3;
  localparam logic [EN_W-1:0] EN_ON  = 3'b011;
  localparam logic [EN_W-1:0] EN_OFF = 3'b100;

  localparam int unsigned SEL_W = 5;
  localparam logic [SEL_W-1:0] SEL_CODE0 = 5'b00111;
  localparam logic [SEL_W-1:0] SEL_CODE1 = 5'b11001;
  localparam logic [SEL_W-1:0] SEL_CODE2 = 5'b01010;
  localparam logic [SEL_W-1:0] SEL_CODE3 = 5'b10100;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_TERM = 2'b10
  } ctl_state_e;

endpackage

// File: rtl/spg_rst_sync.sv
module spg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/spg_en_check.sv
module spg_en_check import spg_pkg::*; #(
  parameter int unsigned NUM_EN = 26
) (
  input  logic [NUM_EN*EN_W-1:0] en_vec_i,
  output logic                   err_o
);

  logic [NUM_EN-1:0] bad;

  for (genvar g = 0; g < NUM_EN; g++) begin : g_field
    logic [EN_W-1:0] code;
    assign code   = en_vec_i[g*EN_W +: EN_W];
    assign bad[g] = !((code == EN_ON) || (code == EN_OFF));
  end

  assign err_o = |bad;

endmodule

// File: rtl/spg_sel_check.sv
module spg_sel_check import spg_pkg::*; #(
  parameter int unsigned          NUM_SEL   = 4,
  parameter logic [NUM_SEL-1:0]   FULL_MASK = '1
) (
  input  logic [NUM_SEL*SEL_W-1:0] sel_vec_i,
  output logic                     err_o
);

  logic [NUM_SEL-1:0] bad;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_field
    logic [SEL_W-1:0] code;
    logic             base_ok;
    assign code    = sel_vec_i[g*SEL_W +: SEL_W];
    assign base_ok = (code == SEL_CODE0) || (code == SEL_CODE1);
    if (FULL_MASK[g]) begin : g_wide
      assign bad[g] = !(base_ok || (code == SEL_CODE2) || (code == SEL_CODE3));
    end else begin : g_narrow
      assign bad[g] = !base_ok;
    end
  end

  assign err_o = |bad;

endmodule

// File: rtl/spg_ctrl_fsm.sv
module spg_ctrl_fsm import spg_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       done_i,
  input  logic       fault_i,
  output logic       run_o,
  output logic       term_o
);

  ctl_state_e state_d, state_q;

  always_comb begin
    state_d = state_q;
    if (fault_i) begin
      state_d = ST_TERM;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) state_d = ST_RUN;
        ST_RUN:  if (done_i)  state_d = ST_IDLE;
        ST_TERM: state_d = ST_TERM;
        default: state_d = ST_TERM;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign run_o  = (state_q == ST_RUN);
  assign term_o = (state_q != ST_IDLE) && (state_q != ST_RUN);

endmodule

// File: rtl/spctl_guard.sv
module spctl_guard import spg_pkg::*; #(
  parameter int unsigned        KEY_SHARES    = 2,
  parameter int unsigned        KEY_WORDS     = 8,
  parameter int unsigned        CTR_SLICES    = 8,
  parameter int unsigned        NUM_SEL       = 4,
  parameter logic [NUM_SEL-1:0] SEL_FULL_MASK = 4'b0101,
  localparam int unsigned       NUM_EN        = KEY_SHARES * KEY_WORDS + CTR_SLICES + 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_EN*EN_W-1:0]   en_vec_i,
  input  logic [NUM_SEL*SEL_W-1:0] sel_vec_i,
  input  logic                     start_i,
  input  logic                     done_i,
  input  logic                     out_req_i,
  output logic                     data_we_o,
  output logic                     err_o,
  output logic                     alert_fatal_o
);

  logic rst_n_sync;
  logic en_err_now;
  logic en_err_q;
  logic sel_err;
  logic run;
  logic term;
  logic alert_set;
  logic alert_q;

  spg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  spg_en_check #(.NUM_EN(NUM_EN)) u_en_check (
    .en_vec_i (en_vec_i),
    .err_o    (en_err_now)
  );

  spg_sel_check #(.NUM_SEL(NUM_SEL), .FULL_MASK(SEL_FULL_MASK)) u_sel_check (
    .sel_vec_i (sel_vec_i),
    .err_o     (sel_err)
  );

  // Registered enable fault breaks the path from codes to controller.
  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      en_err_q <= 1'b0;
    end else begin
      en_err_q <= en_err_now;
    end
  end

  spg_ctrl_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_sync),
    .start_i (start_i),
    .done_i  (done_i),
    .fault_i (en_err_q | sel_err),
    .run_o   (run),
    .term_o  (term)
  );

  assign alert_set = en_err_q | term;

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      alert_q <= 1'b0;
    end else if (alert_set) begin
      alert_q <= 1'b1;
    end
  end

  assign data_we_o     = out_req_i & run & ~term & ~en_err_now & ~sel_err;
  assign err_o         = term;
  assign alert_fatal_o = alert_q;

endmodule

// File: rtl/spg_checker.sv
module spg_checker (
  input logic clk_i,
  input logic rst_n,
  input logic en_err_now,
  input logic en_err_q,
  input logic sel_err,
  input logic term,
  input logic data_we,
  input logic alert
);

  p_sel_term_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    sel_err |=> term);

  p_en_term_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    en_err_q |=> term);

  p_term_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    term |=> term);

  p_alert_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    alert |=> alert);

  p_alert_after_term_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    term |=> alert);

  p_alert_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(alert) |-> $past(en_err_q | term));

  p_we_block_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en_err_now | sel_err | term) |-> !data_we);

endmodule

bind spctl_guard spg_checker u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_n_sync),
  .en_err_now (en_err_now),
  .en_err_q   (en_err_q),
  .sel_err    (sel_err),
  .term       (term),
  .data_we    (data_we_o),
  .alert      (alert_fatal_o)
);

// File: tb/tb_spctl_guard.sv
`timescale 1ns/1ps
module tb_spctl_guard;

  localparam int NEN  = 26;
  localparam int NSEL = 4;
  localparam logic [2:0] ON  = 3'b011;
  localparam logic [2:0] OFF = 3'b100;
  localparam logic [4:0] SC0 = 5'b00111;
  localparam logic [4:0] SC1 = 5'b11001;
  localparam logic [4:0] SC2 = 5'b01010;
  localparam logic [4:0] SC3 = 5'b10100;

  logic clk = 1'b0;
  logic rst_ni;
  logic [NEN*3-1:0] en_vec;
  logic [NSEL*5-1:0] sel_vec;
  logic start_i, done_i, out_req_i;
  logic data_we_o, err_o, alert_fatal_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  spctl_guard dut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .en_vec_i      (en_vec),
    .sel_vec_i     (sel_vec),
    .start_i       (start_i),
    .done_i        (done_i),
    .out_req_i     (out_req_i),
    .data_we_o     (data_we_o),
    .err_o         (err_o),
    .alert_fatal_o (alert_fatal_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] en_base(input int i);
    return (i % 2 == 0) ? ON : OFF;
  endfunction

  task automatic legal_codes();
    for (int i = 0; i < NEN; i++) en_vec[i*3 +: 3] = en_base(i);
    for (int j = 0; j < NSEL; j++) sel_vec[j*5 +: 5] = (j % 2 == 0) ? SC0 : SC1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; start_i = 1'b0; done_i = 1'b0; out_req_i = 1'b0;
    legal_codes();
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic go_run();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    out_req_i = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_ni = 1'b0; start_i = 1'b0; done_i = 1'b0; out_req_i = 1'b1;
    legal_codes();
    @(negedge clk);
    chk("R1 err in reset", err_o, 1'b0);
    chk("R1 alert in reset", alert_fatal_o, 1'b0);
    chk("R1 we in reset", data_we_o, 1'b0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 err after reset", err_o, 1'b0);
    chk("R1 we idle after reset", data_we_o, 1'b0);
    out_req_i = 1'b0;
  endtask

  task automatic t_normal();
    do_reset();
    go_run();
    chk("R8 start enters run", data_we_o, 1'b1);
    chk("R7 we in run with legal codes", data_we_o, 1'b1);
    for (int j = 0; j < NSEL; j += 2) sel_vec[j*5 +: 5] = SC3;
    sel_vec[0 +: 5] = SC2;
    #1;
    chk("R3 wide selector accepts other codes", data_we_o, 1'b1);
    repeat (3) @(negedge clk);
    chk("R3 no terminal on legal wide codes", err_o, 1'b0);
    out_req_i = 1'b0; #1;
    chk("R7 we low without request", data_we_o, 1'b0);
    done_i = 1'b1;
    @(negedge clk);
    done_i = 1'b0; out_req_i = 1'b1; #1;
    chk("R8 done returns to idle", data_we_o, 1'b0);
    out_req_i = 1'b0;
  endtask

  task automatic t_en_fault(input int idx, input logic [2:0] mask, input bit expect_err);
    do_reset();
    go_run();
    en_vec[idx*3 +: 3] = en_base(idx) ^ mask;
    #1;
    if (expect_err) begin
      chk("R7 we blocked same cycle on enable fault", data_we_o, 1'b0);
      @(negedge clk);
      legal_codes();
      chk("R4 enable fault not yet terminal", err_o, 1'b0);
      @(negedge clk);
      chk("R2 R4 enable fault reaches terminal", err_o, 1'b1);
      chk("R6 alert on enable fault", alert_fatal_o, 1'b1);
      start_i = 1'b1; done_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; done_i = 1'b0;
      @(negedge clk); #1;
      chk("R5 terminal sticky", err_o, 1'b1);
      chk("R6 alert sticky", alert_fatal_o, 1'b1);
      chk("R7 we held low in terminal", data_we_o, 1'b0);
    end else begin
      chk("R2 inverted code legal, we stays", data_we_o, 1'b1);
      repeat (2) @(negedge clk);
      chk("R2 inverted code no terminal", err_o, 1'b0);
      chk("R2 inverted code no alert", alert_fatal_o, 1'b0);
    end
    out_req_i = 1'b0;
  endtask

  task automatic t_sel_fault(input int idx, input logic [4:0] code, input bit expect_err);
    do_reset();
    go_run();
    sel_vec[idx*5 +: 5] = code;
    #1;
    if (expect_err) begin
      chk("R7 we blocked same cycle on selector fault", data_we_o, 1'b0);
      @(negedge clk);
      legal_codes();
      chk("R3 R4 selector fault terminal after one edge", err_o, 1'b1);
      chk("R6 alert not before next edge", alert_fatal_o, 1'b0);
      @(negedge clk); #1;
      chk("R6 alert follows terminal", alert_fatal_o, 1'b1);
      chk("R5 terminal holds with legal codes", err_o, 1'b1);
      chk("R7 we low after restore", data_we_o, 1'b0);
    end else begin
      chk("R3 legal selector code keeps we", data_we_o, 1'b1);
      repeat (2) @(negedge clk);
      chk("R3 legal selector code no terminal", err_o, 1'b0);
    end
    out_req_i = 1'b0;
  endtask

  task automatic t_reset_clears();
    do_reset();
    sel_vec[4:0] = 5'b00000;
    repeat (3) @(negedge clk);
    legal_codes();
    chk("R9 terminal before reset", err_o, 1'b1);
    rst_ni = 1'b0;
    #1;
    chk("R9 reset clears terminal", err_o, 1'b0);
    chk("R9 reset clears alert", alert_fatal_o, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; out_req_i = 1'b1; #1;
    chk("R9 still held one edge after release", data_we_o, 1'b0);
    out_req_i = 1'b0;
    repeat (2) @(negedge clk);
    go_run();
    chk("R9 normal after release", data_we_o, 1'b1);
    out_req_i = 1'b0;
  endtask

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; done_i = 1'b0; out_req_i = 1'b0;
    legal_codes();
    t_reset();
    t_normal();
    for (int i = 0; i < NEN; i++) begin
      t_en_fault(i, 3'b001, 1'b1);
      t_en_fault(i, 3'b010, 1'b1);
      t_en_fault(i, 3'b100, 1'b1);
      t_en_fault(i, 3'b011, 1'b1);
      t_en_fault(i, 3'b101, 1'b1);
      t_en_fault(i, 3'b110, 1'b1);
    end
    t_en_fault(3, 3'b111, 1'b0);
    t_en_fault(8, 3'b111, 1'b0);
    for (int j = 0; j < NSEL; j++) begin
      for (int b = 0; b < 5; b++) t_sel_fault(j, SC0 ^ (5'b00001 << b), 1'b1);
      t_sel_fault(j, SC0 ^ 5'b00011, 1'b1);
      t_sel_fault(j, SC1 ^ 5'b11000, 1'b1);
      t_sel_fault(j, SC1, 1'b0);
    end
    t_sel_fault(1, SC2, 1'b1);
    t_sel_fault(3, SC3, 1'b1);
    t_sel_fault(2, SC2, 1'b0);
    t_reset_clears();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule